// File: doc/BRIEF.md
# Instruction Length Decoder

This block accepts a stream of instruction bytes for a small 16-bit subset of a variable-length instruction set. It takes one byte on each cycle where `in_valid` and `in_ready` are both high. It finds the boundary of every instruction as the bytes arrive. Length is not a property of the opcode alone. It is built up step by step from an optional operand-size prefix, the class of the opcode and the contents of the operand-descriptor (mod r/m) byte. As a result, the immediate field can be one, two or four bytes long.

When the last byte of an instruction is accepted, the block registers a descriptor. The descriptor carries:
- the total length and the opcode;
- flags for the prefix, the mod r/m byte and the address field;
- the immediate length;
- the little-endian address and immediate values;
- flags for illegal opcodes and unsupported addressing forms.

A downstream decode stage uses this descriptor to cut the byte stream into whole instructions without rescanning.

Top module: `insn_len_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears any partly collected instruction. While `rst` is high, `d_valid` and `in_ready` are low. After reset, the next accepted byte is treated as the first byte of a new instruction.
- R2: Opcodes 98h and 99h are complete in one byte. They give `d_len`=1, no mod r/m byte, no address and `d_imm_len`=0.
- R3: Opcode CDh takes one following byte, the interrupt number. It gives `d_len`=2, `d_imm_len`=1, and that byte appears in `d_imm[7:0]`.
- R4: Opcodes 01h, 03h, 29h, 2Bh, 89h, 8Bh, F7h and FFh are followed by a mod r/m byte and carry no immediate. When mod (bits 7:6) is 11b, no address follows and `d_len`=2.
- R5: A mod r/m byte with mod=00b and r/m (bits 2:0)=110b is followed by a two-byte address, low byte first. For example, 8B 1E 02 00 gives `d_len`=4, `d_addr_present`=1 and `d_addr`=0002h.
- R6: Opcode 83h carries a mod r/m byte and a one-byte immediate. Opcode 81h carries a mod r/m byte and a two-byte immediate, low byte first. The immediate follows any address bytes. For example, 81 C3 4B 02 gives `d_len`=4 and `d_imm`=024Bh.
- R7: A leading byte 66h sets `d_prefix` and counts in `d_len`, and the next byte is taken as the opcode. Under the prefix, the 81h immediate grows to four bytes. So 66 81 06 a0 a1 i0 i1 i2 i3 gives `d_len`=9.
- R8: The prefix does not widen the one-byte immediates of 83h and CDh.
- R9: Any mod r/m pattern other than mod=11b or mod=00b with r/m=110b sets `d_unsupported`. Such a pattern consumes no address bytes, but any immediate still follows.
- R10: Any other opcode completes at once with `d_illegal`=1. `d_len` is 1, or 2 with a prefix.
- R11: `d_valid` is high for exactly one cycle per instruction: the cycle after the edge that accepted the final byte. A following instruction may start on the next cycle, so descriptors can come on consecutive cycles. Idle cycles between bytes do not change the result.
- R12: `in_ready` is high in every cycle that `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An instruction byte is offered |
| in_ready | output | 1 | The block accepts a byte this cycle |
| in_byte | input | 8 | Instruction byte |
| d_valid | output | 1 | Descriptor valid (one cycle per instruction) |
| d_len | output | 4 | Total instruction length in bytes |
| d_opcode | output | 8 | Opcode byte |
| d_prefix | output | 1 | Operand-size prefix was present |
| d_modrm | output | 1 | A mod r/m byte was present |
| d_addr_present | output | 1 | A two-byte address field was present |
| d_imm_len | output | 3 | Immediate length in bytes (0, 1, 2 or 4) |
| d_addr | output | 16 | Address field, little-endian assembled |
| d_imm | output | 32 | Immediate field, little-endian assembled, zero-filled |
| d_illegal | output | 1 | Opcode not in the supported set |
| d_unsupported | output | 1 | Mod r/m addressing form not supported |

## Verification
Every descriptor is due one clock after the rising edge that accepts the final byte of its instruction. Bytes are driven on falling edges. A monitor samples `d_valid` and the fields on each falling edge, so it sees each registered result in the middle of the one cycle it is valid. The monitor also records the cycle number of each capture. With these records, the tests check the exact count of descriptors after each stream, and check that back-to-back one-byte instructions produce descriptors on consecutive cycles. Reset behaviour is sampled on the falling edge while `rst` is high, before any byte is offered.

// File: rtl/ild_pkg.sv
package ild_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 2;
    localparam int IMM_MAX    = 4;
    localparam int LEN_W      = 4;
    localparam int IMM_LEN_W  = $clog2(IMM_MAX + 1);
    localparam int IDX_W      = $clog2(IMM_MAX);
    localparam int ADDR_W     = BYTE_W * ADDR_BYTES;
    localparam int IMM_W      = BYTE_W * IMM_MAX;

    localparam logic [BYTE_W-1:0] OP_SXT_BW  = 8'h98;
    localparam logic [BYTE_W-1:0] OP_SXT_WD  = 8'h99;
    localparam logic [BYTE_W-1:0] OP_SWI     = 8'hCD;
    localparam logic [BYTE_W-1:0] OP_ALU_IB  = 8'h83;
    localparam logic [BYTE_W-1:0] OP_ALU_IW  = 8'h81;
    localparam logic [BYTE_W-1:0] OP_UNARY   = 8'hF7;
    localparam logic [BYTE_W-1:0] OP_GRP_FF  = 8'hFF;
    localparam logic [BYTE_W-1:0] OP_ADD_ST  = 8'h01;
    localparam logic [BYTE_W-1:0] OP_ADD_LD  = 8'h03;
    localparam logic [BYTE_W-1:0] OP_SUB_ST  = 8'h29;
    localparam logic [BYTE_W-1:0] OP_SUB_LD  = 8'h2B;
    localparam logic [BYTE_W-1:0] OP_MOV_ST  = 8'h89;
    localparam logic [BYTE_W-1:0] OP_MOV_LD  = 8'h8B;

    typedef enum logic [2:0] {
        ST_FIRST  = 3'd0,
        ST_OPCODE = 3'd1,
        ST_MODRM  = 3'd2,
        ST_ADDR   = 3'd3,
        ST_IMM    = 3'd4
    } ild_state_e;

    typedef struct packed {
        logic [LEN_W-1:0]     len;
        logic [BYTE_W-1:0]    opcode;
        logic                 prefix;
        logic                 modrm;
        logic                 addr_present;
        logic [IMM_LEN_W-1:0] imm_len;
        logic [ADDR_W-1:0]    addr;
        logic [IMM_W-1:0]     imm;
        logic                 illegal;
        logic                 unsupported;
    } ild_desc_t;
endpackage

// File: rtl/ild_opclass.sv
module ild_opclass
    import ild_pkg::*;
(
    input  logic [BYTE_W-1:0]    opcode,
    input  logic                 wide,
    output logic                 need_modrm,
    output logic [IMM_LEN_W-1:0] imm_len,
    output logic                 illegal
);
    localparam logic [IMM_LEN_W-1:0] IMM_ONE  = IMM_LEN_W'(1);
    localparam logic [IMM_LEN_W-1:0] IMM_WORD = IMM_LEN_W'(IMM_MAX / 2);
    localparam logic [IMM_LEN_W-1:0] IMM_DWRD = IMM_LEN_W'(IMM_MAX);

    always_comb begin
        need_modrm = 1'b0;
        imm_len    = '0;
        illegal    = 1'b0;
        case (opcode)
            OP_SXT_BW, OP_SXT_WD: begin
            end
            OP_SWI: begin
                imm_len = IMM_ONE;
            end
            OP_ALU_IB: begin
                need_modrm = 1'b1;
                imm_len    = IMM_ONE;
            end
            OP_ALU_IW: begin
                need_modrm = 1'b1;
                imm_len    = wide ? IMM_DWRD : IMM_WORD;
            end
            OP_UNARY, OP_GRP_FF, OP_ADD_ST, OP_ADD_LD,
            OP_SUB_ST, OP_SUB_LD, OP_MOV_ST, OP_MOV_LD: begin
                need_modrm = 1'b1;
            end
            default: begin
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ild_modrm.sv
module ild_modrm (
    input  logic [1:0] mode,
    input  logic [2:0] rm,
    output logic       addr_present,
    output logic       unsupported
);
    localparam logic [1:0] MODE_REG    = 2'b11;
    localparam logic [1:0] MODE_MEM    = 2'b00;
    localparam logic [2:0] RM_DIRECT   = 3'b110;

    always_comb begin
        addr_present = 1'b0;
        unsupported  = 1'b0;
        if (mode == MODE_REG) begin
            addr_present = 1'b0;
        end else if (mode == MODE_MEM && rm == RM_DIRECT) begin
            addr_present = 1'b1;
        end else begin
            unsupported = 1'b1;
        end
    end
endmodule

// File: rtl/ild_fsm.sv
module ild_fsm
    import ild_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PREFIX_CODE = 8'h66
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [BYTE_W-1:0]    in_byte,
    output logic                 in_ready,
    output logic                 cur_prefix,
    input  logic                 cls_modrm,
    input  logic [IMM_LEN_W-1:0] cls_imm_len,
    input  logic                 cls_illegal,
    input  logic                 mr_addr,
    input  logic                 mr_unsup,
    output logic                 d_valid,
    output ild_desc_t            d_out
);
    typedef struct packed {
        ild_state_e       state;
        logic [IDX_W-1:0] idx;
        ild_desc_t        cur;
        ild_desc_t        out;
        logic             out_valid;
    } fsm_t;

    fsm_t             st_d, st_q;
    ild_desc_t        work;
    ild_state_e       next_state;
    logic [IDX_W-1:0] next_idx;
    logic             fire, take_op, done;

    assign in_ready   = !rst;
    assign fire       = in_valid && in_ready;
    assign cur_prefix = st_q.cur.prefix;
    assign d_valid    = st_q.out_valid;
    assign d_out      = st_q.out;

    always_comb begin
        st_d          = st_q;
        st_d.out_valid = 1'b0;
        work          = st_q.cur;
        next_state    = st_q.state;
        next_idx      = st_q.idx;
        take_op       = 1'b0;
        done          = 1'b0;
        if (fire) begin
            work.len = st_q.cur.len + 1'b1;
            case (st_q.state)
                ST_FIRST: begin
                    if (in_byte == PREFIX_CODE) begin
                        work.prefix = 1'b1;
                        next_state  = ST_OPCODE;
                    end else begin
                        take_op = 1'b1;
                    end
                end
                ST_OPCODE: begin
                    take_op = 1'b1;
                end
                ST_MODRM: begin
                    work.addr_present = mr_addr;
                    work.unsupported  = mr_unsup;
                    next_idx          = '0;
                    if (mr_addr) begin
                        next_state = ST_ADDR;
                    end else if (work.imm_len != '0) begin
                        next_state = ST_IMM;
                    end else begin
                        done = 1'b1;
                    end
                end
                ST_ADDR: begin
                    work.addr[st_q.idx*BYTE_W +: BYTE_W] = in_byte;
                    if (st_q.idx == IDX_W'(ADDR_BYTES - 1)) begin
                        next_idx = '0;
                        if (work.imm_len != '0) begin
                            next_state = ST_IMM;
                        end else begin
                            done = 1'b1;
                        end
                    end else begin
                        next_idx = st_q.idx + 1'b1;
                    end
                end
                ST_IMM: begin
                    work.imm[st_q.idx*BYTE_W +: BYTE_W] = in_byte;
                    if (IMM_LEN_W'(st_q.idx) == IMM_LEN_W'(work.imm_len - 1'b1)) begin
                        done = 1'b1;
                    end else begin
                        next_idx = st_q.idx + 1'b1;
                    end
                end
                default: begin
                    next_state = ST_FIRST;
                end
            endcase

            if (take_op) begin
                work.opcode  = in_byte;
                work.modrm   = cls_modrm;
                work.imm_len = cls_imm_len;
                work.illegal = cls_illegal;
                next_idx     = '0;
                if (cls_modrm) begin
                    next_state = ST_MODRM;
                end else if (cls_imm_len != '0) begin
                    next_state = ST_IMM;
                end else begin
                    done = 1'b1;
                end
            end

            if (done) begin
                st_d.out       = work;
                st_d.out_valid = 1'b1;
                st_d.cur       = '0;
                st_d.state     = ST_FIRST;
                st_d.idx       = '0;
            end else begin
                st_d.cur   = work;
                st_d.state = next_state;
                st_d.idx   = next_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R11: a descriptor only follows an accepted byte
    a_r11_after_handshake: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> $past(fire));

    // R7: reported length equals the sum of the reported fields
    a_r7_len_sum: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> (d_out.len == LEN_W'(d_out.prefix) + LEN_W'(1) + LEN_W'(d_out.modrm)
                     + (d_out.addr_present ? LEN_W'(ADDR_BYTES) : LEN_W'(0))
                     + LEN_W'(d_out.imm_len)));

    // R5: an address field never appears without a mod r/m byte
    a_r5_addr_needs_modrm: assert property (@(posedge clk) disable iff (rst)
        (d_valid && d_out.addr_present) |-> d_out.modrm);

    // R9: unsupported forms consume no address bytes
    a_r9_unsup_no_addr: assert property (@(posedge clk) disable iff (rst)
        (d_valid && d_out.unsupported) |-> !d_out.addr_present);

    // R8: a four-byte immediate requires the prefix
    a_r8_wide_needs_prefix: assert property (@(posedge clk) disable iff (rst)
        (d_valid && d_out.imm_len == IMM_LEN_W'(IMM_MAX)) |-> d_out.prefix);

    // R10: illegal opcodes are one byte past any prefix
    a_r10_illegal_short: assert property (@(posedge clk) disable iff (rst)
        (d_valid && d_out.illegal) |-> (d_out.len == LEN_W'(d_out.prefix) + LEN_W'(1)));
endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
    import ild_pkg::*;
#(
    parameter logic [7:0] PREFIX_CODE = 8'h66
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_byte,
    output logic        d_valid,
    output logic [3:0]  d_len,
    output logic [7:0]  d_opcode,
    output logic        d_prefix,
    output logic        d_modrm,
    output logic        d_addr_present,
    output logic [2:0]  d_imm_len,
    output logic [15:0] d_addr,
    output logic [31:0] d_imm,
    output logic        d_illegal,
    output logic        d_unsupported
);
    logic                 cur_prefix;
    logic                 cls_modrm, cls_illegal;
    logic [IMM_LEN_W-1:0] cls_imm_len;
    logic                 mr_addr, mr_unsup;
    ild_desc_t            desc;

    ild_opclass u_opclass (
        .opcode     (in_byte),
        .wide       (cur_prefix),
        .need_modrm (cls_modrm),
        .imm_len    (cls_imm_len),
        .illegal    (cls_illegal)
    );

    ild_modrm u_modrm (
        .mode         (in_byte[7:6]),
        .rm           (in_byte[2:0]),
        .addr_present (mr_addr),
        .unsupported  (mr_unsup)
    );

    ild_fsm #(.PREFIX_CODE(PREFIX_CODE)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .in_ready    (in_ready),
        .cur_prefix  (cur_prefix),
        .cls_modrm   (cls_modrm),
        .cls_imm_len (cls_imm_len),
        .cls_illegal (cls_illegal),
        .mr_addr     (mr_addr),
        .mr_unsup    (mr_unsup),
        .d_valid     (d_valid),
        .d_out       (desc)
    );

    assign d_len          = desc.len;
    assign d_opcode       = desc.opcode;
    assign d_prefix       = desc.prefix;
    assign d_modrm        = desc.modrm;
    assign d_addr_present = desc.addr_present;
    assign d_imm_len      = desc.imm_len;
    assign d_addr         = desc.addr;
    assign d_imm          = desc.imm;
    assign d_illegal      = desc.illegal;
    assign d_unsupported  = desc.unsupported;
endmodule

// File: tb/insn_len_decoder_bench.sv
`timescale 1ns/1ps
module insn_len_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = 8'h00;
    logic        d_valid;
    logic [3:0]  d_len;
    logic [7:0]  d_opcode;
    logic        d_prefix, d_modrm, d_addr_present;
    logic [2:0]  d_imm_len;
    logic [15:0] d_addr;
    logic [31:0] d_imm;
    logic        d_illegal, d_unsupported;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cap_n  = 0;
    logic [67:0] cap     [0:15];
    int          cap_cyc [0:15];

    always #5 clk = ~clk;

    insn_len_decoder u_insn_len_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .d_valid(d_valid), .d_len(d_len), .d_opcode(d_opcode), .d_prefix(d_prefix),
        .d_modrm(d_modrm), .d_addr_present(d_addr_present), .d_imm_len(d_imm_len),
        .d_addr(d_addr), .d_imm(d_imm), .d_illegal(d_illegal), .d_unsupported(d_unsupported)
    );

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, cycle %0d expected below 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (d_valid && cap_n < 16) begin
            cap[cap_n]     = {d_len, d_opcode, d_prefix, d_modrm, d_addr_present, d_imm_len,
                              d_addr, d_imm, d_illegal, d_unsupported};
            cap_cyc[cap_n] = cyc;
            cap_n          = cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic begin_test();
        gap(1);
        cap_n = 0;
    endtask

    task automatic expect_count(input string req, input int n);
        gap(3);
        check(cap_n == n, req, "descriptor count", cap_n, n);
    endtask

    task automatic check_desc(input int i, input string req,
                              input logic [3:0] len, input logic [7:0] opc,
                              input bit pfx, input bit mrm, input bit ap,
                              input logic [2:0] il, input logic [15:0] addr,
                              input logic [31:0] imm, input bit ill, input bit uns);
        logic [67:0] exp;
        exp = {len, opc, pfx, mrm, ap, il, addr, imm, ill, uns};
        checks = checks + 1;
        if (cap[i] !== exp) begin
            fails = fails + 1;
            $display("FAIL %s descriptor %0d: actual %h expected %h", req, i, cap[i], exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(d_valid == 1'b0, "R1", "d_valid in reset", d_valid, 0);
        check(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R12", "in_ready after reset", in_ready, 1);
    endtask

    task automatic t_one_byte();
        begin_test();
        put(8'h98); put(8'h99); put(8'h98);
        expect_count("R2", 3);
        check_desc(0, "R2", 4'd1, 8'h98, 0, 0, 0, 3'd0, 16'h0, 32'h0, 0, 0);
        check_desc(1, "R2", 4'd1, 8'h99, 0, 0, 0, 3'd0, 16'h0, 32'h0, 0, 0);
        check(cap_cyc[1] == cap_cyc[0] + 1 && cap_cyc[2] == cap_cyc[1] + 1,
              "R11", "back-to-back spacing", cap_cyc[2] - cap_cyc[0], 2);
    endtask

    task automatic t_swi();
        begin_test();
        put(8'hCD); put(8'h21);
        expect_count("R3", 1);
        check_desc(0, "R3", 4'd2, 8'hCD, 0, 0, 0, 3'd1, 16'h0, 32'h21, 0, 0);
    endtask

    task automatic t_reg();
        begin_test();
        put(8'h01); put(8'hC8);
        put(8'hF7); put(8'hD8);
        expect_count("R4", 2);
        check_desc(0, "R4", 4'd2, 8'h01, 0, 1, 0, 3'd0, 16'h0, 32'h0, 0, 0);
        check_desc(1, "R4", 4'd2, 8'hF7, 0, 1, 0, 3'd0, 16'h0, 32'h0, 0, 0);
    endtask

    task automatic t_mem();
        begin_test();
        put(8'h8B); put(8'h1E); put(8'h02); put(8'h00);
        put(8'h89); put(8'h1E); put(8'h04); put(8'hA5);
        expect_count("R5", 2);
        check_desc(0, "R5", 4'd4, 8'h8B, 0, 1, 1, 3'd0, 16'h0002, 32'h0, 0, 0);
        check_desc(1, "R5", 4'd4, 8'h89, 0, 1, 1, 3'd0, 16'hA504, 32'h0, 0, 0);
    endtask

    task automatic t_imm();
        begin_test();
        put(8'h81); put(8'hC3); put(8'h4B); put(8'h02);
        put(8'h83); put(8'hC0); put(8'h05);
        put(8'h81); put(8'h06); put(8'h10); put(8'h20); put(8'h33); put(8'h44);
        expect_count("R6", 3);
        check_desc(0, "R6", 4'd4, 8'h81, 0, 1, 0, 3'd2, 16'h0, 32'h024B, 0, 0);
        check_desc(1, "R6", 4'd3, 8'h83, 0, 1, 0, 3'd1, 16'h0, 32'h05, 0, 0);
        check_desc(2, "R6", 4'd6, 8'h81, 0, 1, 1, 3'd2, 16'h2010, 32'h4433, 0, 0);
    endtask

    task automatic t_prefix();
        begin_test();
        put(8'h66); put(8'h81); put(8'h06); put(8'h34); put(8'h12);
        put(8'h78); put(8'h56); put(8'h34); put(8'h12);
        put(8'h66); put(8'h81); put(8'hC1); put(8'hEF); put(8'hBE); put(8'hAD); put(8'hDE);
        expect_count("R7", 2);
        check_desc(0, "R7", 4'd9, 8'h81, 1, 1, 1, 3'd4, 16'h1234, 32'h12345678, 0, 0);
        check_desc(1, "R7", 4'd7, 8'h81, 1, 1, 0, 3'd4, 16'h0, 32'hDEADBEEF, 0, 0);
    endtask

    task automatic t_prefix_narrow();
        begin_test();
        put(8'h66); put(8'h83); put(8'hC0); put(8'h7F);
        put(8'h66); put(8'hCD); put(8'h10);
        put(8'h98);
        expect_count("R8", 3);
        check_desc(0, "R8", 4'd4, 8'h83, 1, 1, 0, 3'd1, 16'h0, 32'h7F, 0, 0);
        check_desc(1, "R8", 4'd3, 8'hCD, 1, 0, 0, 3'd1, 16'h0, 32'h10, 0, 0);
        check_desc(2, "R8", 4'd1, 8'h98, 0, 0, 0, 3'd0, 16'h0, 32'h0, 0, 0);
    endtask

    task automatic t_unsup();
        begin_test();
        put(8'h8B); put(8'h07);
        put(8'h81); put(8'h47); put(8'h11); put(8'h22);
        expect_count("R9", 2);
        check_desc(0, "R9", 4'd2, 8'h8B, 0, 1, 0, 3'd0, 16'h0, 32'h0, 0, 1);
        check_desc(1, "R9", 4'd4, 8'h81, 0, 1, 0, 3'd2, 16'h0, 32'h2211, 0, 1);
    endtask

    task automatic t_illegal();
        begin_test();
        put(8'h0F);
        put(8'h66); put(8'h0F);
        put(8'h66); put(8'h66);
        expect_count("R10", 3);
        check_desc(0, "R10", 4'd1, 8'h0F, 0, 0, 0, 3'd0, 16'h0, 32'h0, 1, 0);
        check_desc(1, "R10", 4'd2, 8'h0F, 1, 0, 0, 3'd0, 16'h0, 32'h0, 1, 0);
        check_desc(2, "R10", 4'd2, 8'h66, 1, 0, 0, 3'd0, 16'h0, 32'h0, 1, 0);
    endtask

    task automatic t_stall();
        begin_test();
        put(8'h8B); gap(2);
        put(8'h1E); gap(1);
        put(8'hCD); gap(3);
        put(8'hAB);
        expect_count("R11", 1);
        check_desc(0, "R11", 4'd4, 8'h8B, 0, 1, 1, 3'd0, 16'hABCD, 32'h0, 0, 0);
    endtask

    task automatic t_reset_mid();
        begin_test();
        put(8'h66); put(8'h8B); put(8'h1E);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(d_valid == 1'b0 && in_ready == 1'b0, "R1", "outputs during mid reset",
              {d_valid, in_ready}, 0);
        rst = 1'b0;
        put(8'h99);
        expect_count("R1", 1);
        check_desc(0, "R1", 4'd1, 8'h99, 0, 0, 0, 3'd0, 16'h0, 32'h0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_one_byte();
        t_swi();
        t_reg();
        t_mem();
        t_imm();
        t_prefix();
        t_prefix_narrow();
        t_unsup();
        t_illegal();
        t_stall();
        t_reset_mid();
        gap(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule